// File: doc/BRIEF.md
# Fault Cause Priority Classifier

This block takes a snapshot of a hardware fault and chooses what happens next. The snapshot has three parts. The first is a 4-bit status field that flags a stack overflow, a control-store parity error, a register-file parity error and a memory error. The second is a vector of memory-side error flags. The third is a 16-bit fault-control word. The block returns one of four actions:

- notify the emulator with a trap;
- ignore the fault and resume the interrupted task;
- stop at a breakpoint;
- crash.

A breakpoint or crash comes with an 8-bit crash code. A 2-bit selector says whether software should add the current task number, the pipe's task number, or nothing to that code. When the fault handler must clear the memory error latches, the result also carries a one-cycle pulse asking for that.

The memory-error-only case is time-critical, so it is decoded first. Everything else goes through a fixed priority order. Three bits of the control word steer the result: one enables notification, one asks that crashes become breakpoints, and one makes bus parity errors fatal. A crash that is not turned into a breakpoint stores its code in a panel register. The block then halts until reset.

Top module: `fault_classifier`

## Requirements
- R1: A request is taken only on a clock edge where `ready` is 1 and `req_valid` is 1. `ready` is 0 on the next cycle. The result appears with `out_valid` high for exactly one cycle, on the second edge after acceptance. Requests presented while `ready` is 0 produce no result.
- R2: Status bit positions are: bit 3 stack overflow, bit 2 control-store parity, bit 1 register parity, bit 0 memory error. The memory flags are used only when the status value is exactly 1.
- R3: A status value of 0 gives action breakpoint (code 2), crash code 0x10 and offset current-task (code 1). The control word does not change this.
- R4: If status bit 2 or bit 1 is set, the result is a crash with code 0x20 plus the status value and offset none (code 0). There is no memory-reset pulse.
- R5: If status bit 3 is set and bits 2 and 1 are clear, the fault is a stack fault. Control bit 15 = 1 gives notify (code 0), code 0, offset none. Control bit 15 = 0 gives a crash with code 0x30 and offset none. In both cases `mem_err_reset` pulses with `out_valid`.
- R6: Memory flag positions are: 0 MC1 pipe A, 1 MC1 pipe B, 2 MC2 pipe A, 3 MC2 pipe B, 4 out-of-bounds, 5 bus parity. A bus parity flag, with or without out-of-bounds, is highest priority. With control bit 2 = 0 it gives resume (code 1), code 0, offset none. With control bit 2 = 1 it gives a crash with code 0x48 and offset current-task. Both cases pulse `mem_err_reset`.
- R7: Out-of-bounds alone gives notify when control bit 15 = 1. Otherwise it gives a crash with code 0x40 and offset current-task. Neither case pulses the reset.
- R8: With both MC2 flags set, the result is a crash with code 0x50, offset none and no reset pulse. With exactly one MC2 flag set, the result is a crash with code 0x58, offset pipe-task (code 2) and a reset pulse. MC2 takes priority over MC1.
- R9: Any MC1 flag gives notify when control bit 15 = 1. Otherwise it gives a crash with code 0x60 and offset pipe-task. Both cases pulse the reset. When no memory flag is set, the result is a crash with code 0x68 and offset none.
- R10: When control bit 3 = 1, any crash is reported as a breakpoint instead. The code and offset are kept and the block does not halt.
- R11: A crash with control bit 3 = 0 does the following:
  - sets `halted`;
  - loads `panel_code` with the crash code;
  - holds `ready` at 0 until reset;
  - ignores all later requests.
- R12: After synchronous reset, `ready` = 1, `out_valid` = 0, `halted` = 0, `mem_err_reset` = 0 and `panel_code` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request to classify the presented fault |
| status | input | 4 | Parity/status field |
| mem_flags | input | 6 | Memory-side error flags |
| ctrl | input | 16 | Fault-control word |
| ready | output | 1 | Idle and able to accept a request |
| out_valid | output | 1 | One-cycle result strobe |
| action | output | 2 | 0 notify, 1 resume, 2 breakpoint, 3 crash |
| crash_code | output | 8 | Crash or breakpoint code |
| code_offset | output | 2 | 0 none, 1 current task, 2 pipe task |
| mem_err_reset | output | 1 | Pulse asking to clear memory error latches |
| halted | output | 1 | Block is halted after a crash |
| panel_code | output | 8 | Code shown on the display register |

## Verification
The halted state is the hardest part to observe. Once the block halts, it accepts nothing more. Because of that, every other case has to be run with control bit 3 set, so that crashes come out as breakpoints and the run can continue. The fatal, non-breakpoint crash is saved for the end. There the bench checks the panel register and the stuck `ready`. It then confirms that a further request produces no strobe, and only afterwards resets the block.

A second hard case is proving that requests arriving while busy are ignored. The bench holds `req_valid` high through the busy cycle of a transaction, and the scoreboard flags any strobe it did not expect.

// File: rtl/fault_cls_pkg.sv
package fault_cls_pkg;

    localparam int CODE_W   = 8;
    localparam int STATUS_W = 4;
    localparam int MEMF_W   = 6;
    localparam int CTRL_W   = 16;

    // status field bit positions
    localparam int ST_STACK  = 3;
    localparam int ST_CSPAR  = 2;
    localparam int ST_REGPAR = 1;
    localparam int ST_MEM    = 0;

    // memory flag bit positions
    localparam int MF_MC1A   = 0;
    localparam int MF_MC1B   = 1;
    localparam int MF_MC2A   = 2;
    localparam int MF_MC2B   = 3;
    localparam int MF_OOB    = 4;
    localparam int MF_BUSPAR = 5;

    // control word bit positions
    localparam int CB_NOTIFY       = 15;
    localparam int CB_BREAK        = 3;
    localparam int CB_BUSPAR_FATAL = 2;

    // crash codes
    localparam logic [CODE_W-1:0] CODE_BRK      = 8'h10;
    localparam logic [CODE_W-1:0] CODE_PAR_BASE = 8'h20;
    localparam logic [CODE_W-1:0] CODE_STACK    = 8'h30;
    localparam logic [CODE_W-1:0] CODE_OOB      = 8'h40;
    localparam logic [CODE_W-1:0] CODE_BUSPAR   = 8'h48;
    localparam logic [CODE_W-1:0] CODE_MC2BOTH  = 8'h50;
    localparam logic [CODE_W-1:0] CODE_MC2      = 8'h58;
    localparam logic [CODE_W-1:0] CODE_MC1      = 8'h60;
    localparam logic [CODE_W-1:0] CODE_MCNONE   = 8'h68;

    typedef enum logic [1:0] {
        ACT_NOTIFY = 2'd0,
        ACT_RESUME = 2'd1,
        ACT_BREAK  = 2'd2,
        ACT_CRASH  = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        OFS_NONE  = 2'd0,
        OFS_CTASK = 2'd1,
        OFS_PTASK = 2'd2
    } ofs_e;

    typedef struct packed {
        act_e              act;
        logic [CODE_W-1:0] code;
        ofs_e              ofs;
        logic              clr_mem;
    } verdict_t;

    typedef struct packed {
        logic [STATUS_W-1:0] status;
        logic [MEMF_W-1:0]   memf;
        logic                notify_en;
        logic                break_en;
        logic                buspar_fatal;
    } fault_snap_t;

    function automatic verdict_t mk_verdict(act_e a, logic [CODE_W-1:0] c,
                                            ofs_e o, logic r);
        verdict_t v;
        v.act     = a;
        v.code    = c;
        v.ofs     = o;
        v.clr_mem = r;
        return v;
    endfunction

    // trap-or-die choice shared by several fault kinds
    function automatic verdict_t trap_or_crash(logic notify, logic [CODE_W-1:0] c,
                                               ofs_e o, logic r);
        if (notify)
            return mk_verdict(ACT_NOTIFY, '0, OFS_NONE, r);
        return mk_verdict(ACT_CRASH, c, o, r);
    endfunction

endpackage

// File: rtl/fault_mem_decode.sv
module fault_mem_decode
    import fault_cls_pkg::*;
(
    input  logic [MEMF_W-1:0] memf,
    input  logic              notify_en,
    input  logic              buspar_fatal,
    output verdict_t          verdict
);
    logic mc2_both, mc2_any, mc1_any;

    assign mc2_both = memf[MF_MC2A] & memf[MF_MC2B];
    assign mc2_any  = memf[MF_MC2A] | memf[MF_MC2B];
    assign mc1_any  = memf[MF_MC1A] | memf[MF_MC1B];

    // priority: bus parity, out-of-bounds, MC2 pair, single MC2, MC1, none
    always_comb begin
        if (memf[MF_BUSPAR]) begin
            if (buspar_fatal)
                verdict = mk_verdict(ACT_CRASH, CODE_BUSPAR, OFS_CTASK, 1'b1);
            else
                verdict = mk_verdict(ACT_RESUME, '0, OFS_NONE, 1'b1);
        end else if (memf[MF_OOB]) begin
            verdict = trap_or_crash(notify_en, CODE_OOB, OFS_CTASK, 1'b0);
        end else if (mc2_both) begin
            verdict = mk_verdict(ACT_CRASH, CODE_MC2BOTH, OFS_NONE, 1'b0);
        end else if (mc2_any) begin
            verdict = mk_verdict(ACT_CRASH, CODE_MC2, OFS_PTASK, 1'b1);
        end else if (mc1_any) begin
            verdict = trap_or_crash(notify_en, CODE_MC1, OFS_PTASK, 1'b1);
        end else begin
            verdict = mk_verdict(ACT_CRASH, CODE_MCNONE, OFS_NONE, 1'b0);
        end
    end
endmodule

// File: rtl/fault_status_decode.sv
module fault_status_decode
    import fault_cls_pkg::*;
(
    input  logic [STATUS_W-1:0] status,
    input  logic                notify_en,
    input  verdict_t            mem_verdict,
    output verdict_t            verdict
);
    localparam logic [STATUS_W-1:0] MEM_ONLY = STATUS_W'(1) << ST_MEM;

    logic parity_hit;
    assign parity_hit = status[ST_CSPAR] | status[ST_REGPAR];

    always_comb begin
        if (status == MEM_ONLY) begin
            // time-critical path: memory error with nothing else pending
            verdict = mem_verdict;
        end else if (status == '0) begin
            verdict = mk_verdict(ACT_BREAK, CODE_BRK, OFS_CTASK, 1'b0);
        end else if (parity_hit) begin
            verdict = mk_verdict(ACT_CRASH, CODE_PAR_BASE + CODE_W'(status),
                                 OFS_NONE, 1'b0);
        end else begin
            // only the stack bit remains (possibly with a memory error)
            verdict = trap_or_crash(notify_en, CODE_STACK, OFS_NONE, 1'b1);
        end
    end
endmodule

// File: rtl/fault_break_override.sv
module fault_break_override
    import fault_cls_pkg::*;
(
    input  verdict_t raw,
    input  logic     break_en,
    output verdict_t final_v,
    output logic     will_halt
);
    always_comb begin
        final_v = raw;
        if (raw.act == ACT_CRASH && break_en)
            final_v.act = ACT_BREAK;
    end
    assign will_halt = (final_v.act == ACT_CRASH);
endmodule

// File: rtl/fault_classifier.sv
module fault_classifier
    import fault_cls_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [3:0]  status,
    input  logic [5:0]  mem_flags,
    input  logic [15:0] ctrl,
    output logic        ready,
    output logic        out_valid,
    output logic [1:0]  action,
    output logic [7:0]  crash_code,
    output logic [1:0]  code_offset,
    output logic        mem_err_reset,
    output logic        halted,
    output logic [7:0]  panel_code
);
    typedef enum logic [1:0] {S_IDLE, S_EVAL, S_HALT} state_e;

    state_e      state;
    fault_snap_t snap;
    verdict_t    mem_v, stat_v, fin_v, res_q;
    logic        will_halt;
    logic        accept;

    logic unused_ctrl_bits;
    assign unused_ctrl_bits = ^{ctrl[14:4], ctrl[1:0]};

    assign ready  = (state == S_IDLE);
    assign halted = (state == S_HALT);
    assign accept = ready && req_valid;

    fault_mem_decode u_mem (
        .memf        (snap.memf),
        .notify_en   (snap.notify_en),
        .buspar_fatal(snap.buspar_fatal),
        .verdict     (mem_v)
    );

    fault_status_decode u_stat (
        .status     (snap.status),
        .notify_en  (snap.notify_en),
        .mem_verdict(mem_v),
        .verdict    (stat_v)
    );

    fault_break_override u_brk (
        .raw      (stat_v),
        .break_en (snap.break_en),
        .final_v  (fin_v),
        .will_halt(will_halt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= S_IDLE;
            snap          <= '0;
            res_q         <= '0;
            out_valid     <= 1'b0;
            mem_err_reset <= 1'b0;
            panel_code    <= '0;
        end else begin
            out_valid     <= 1'b0;
            mem_err_reset <= 1'b0;
            unique case (state)
                S_IDLE: if (accept) begin
                    snap.status       <= status;
                    snap.memf         <= mem_flags;
                    snap.notify_en    <= ctrl[CB_NOTIFY];
                    snap.break_en     <= ctrl[CB_BREAK];
                    snap.buspar_fatal <= ctrl[CB_BUSPAR_FATAL];
                    state             <= S_EVAL;
                end
                S_EVAL: begin
                    res_q         <= fin_v;
                    out_valid     <= 1'b1;
                    mem_err_reset <= fin_v.clr_mem;
                    if (will_halt) begin
                        panel_code <= fin_v.code;
                        state      <= S_HALT;
                    end else begin
                        state      <= S_IDLE;
                    end
                end
                S_HALT: state <= S_HALT;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign action      = res_q.act;
    assign crash_code  = res_q.code;
    assign code_offset = res_q.ofs;

    AST_ONE_CYCLE_STROBE: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid); // R1
    AST_STROBE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(accept, 2)); // R1
    AST_RESET_PULSE_IN_STROBE: assert property (@(posedge clk) disable iff (rst)
        mem_err_reset |-> out_valid); // R5
    AST_BREAK_NEVER_CRASH: assert property (@(posedge clk) disable iff (rst)
        (out_valid && snap.break_en) |-> (action != ACT_CRASH)); // R10
    AST_CRASH_HALTS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && action == ACT_CRASH) |-> (halted && panel_code == crash_code)); // R11
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && !out_valid && $stable(panel_code))); // R11
endmodule

// File: tb/test_fault_classifier.sv
module test_fault_classifier;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct packed {
        logic [1:0] act;
        logic [7:0] code;
        logic [1:0] ofs;
        logic       clr;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [3:0]  status = '0;
    logic [5:0]  mem_flags = '0;
    logic [15:0] ctrl = '0;
    logic        ready, out_valid, mem_err_reset, halted;
    logic [1:0]  action, code_offset;
    logic [7:0]  crash_code, panel_code;

    int checks = 0;
    int errors = 0;
    exp_t   exp_q[$];
    string  tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fault_classifier i_fault_classifier (
        .clk(clk), .rst(rst), .req_valid(req_valid), .status(status),
        .mem_flags(mem_flags), .ctrl(ctrl), .ready(ready), .out_valid(out_valid),
        .action(action), .crash_code(crash_code), .code_offset(code_offset),
        .mem_err_reset(mem_err_reset), .halted(halted), .panel_code(panel_code)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act_v, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act_v, exp_v);
        end
    endtask

    // independent expectation model built from the requirement list
    function automatic exp_t model(input logic [3:0] st, input logic [5:0] mf,
                                   input logic [15:0] cw);
        exp_t e;
        e = '{act: 2'd3, code: 8'h00, ofs: 2'd0, clr: 1'b0};
        if (st == 4'd0)                    e = '{2'd2, 8'h10, 2'd1, 1'b0};
        else if (st[2] || st[1])           e = '{2'd3, 8'h20 + {4'h0, st}, 2'd0, 1'b0};
        else if (st != 4'd1)               e = cw[15] ? '{2'd0, 8'h00, 2'd0, 1'b1}
                                                      : '{2'd3, 8'h30, 2'd0, 1'b1};
        else if (mf[5])                    e = cw[2]  ? '{2'd3, 8'h48, 2'd1, 1'b1}
                                                      : '{2'd1, 8'h00, 2'd0, 1'b1};
        else if (mf[4])                    e = cw[15] ? '{2'd0, 8'h00, 2'd0, 1'b0}
                                                      : '{2'd3, 8'h40, 2'd1, 1'b0};
        else if (mf[2] && mf[3])           e = '{2'd3, 8'h50, 2'd0, 1'b0};
        else if (mf[2] || mf[3])           e = '{2'd3, 8'h58, 2'd2, 1'b1};
        else if (mf[0] || mf[1])           e = cw[15] ? '{2'd0, 8'h00, 2'd0, 1'b1}
                                                      : '{2'd3, 8'h60, 2'd2, 1'b1};
        else                               e = '{2'd3, 8'h68, 2'd0, 1'b0};
        if (e.act == 2'd3 && cw[3]) e.act = 2'd2;
        return e;
    endfunction

    // driver: pushes the expectation, drives one request, checks timing (R1)
    task automatic run_case(input logic [3:0] st, input logic [5:0] mf,
                            input logic [15:0] cw, input string tag,
                            input bit hold_busy, input bit halt_exp);
        exp_q.push_back(model(st, mf, cw));
        tag_q.push_back(tag);
        @(negedge clk);
        status = st; mem_flags = mf; ctrl = cw; req_valid = 1'b1;
        @(negedge clk);
        if (!hold_busy) req_valid = 1'b0;
        else begin status = ~st; mem_flags = ~mf; end
        chk(ready == 1'b0 && out_valid == 1'b0, "R1", "busy after accept",
            {ready, out_valid}, 0);
        @(negedge clk);
        req_valid = 1'b0;
        chk(out_valid == 1'b1, "R1", "strobe two edges after accept", out_valid, 1);
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "strobe lasts one cycle", out_valid, 0);
        if (!halt_exp) chk(ready == 1'b1, "R1", "idle again", ready, 1);
    endtask

    // monitor: pops the scoreboard on every strobe
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1", "unexpected strobe", 1, 0);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(action == e.act, t, "action", action, e.act);
                chk(crash_code == e.code, t, "crash_code", crash_code, e.code);
                chk(code_offset == e.ofs, t, "code_offset", code_offset, e.ofs);
                chk(mem_err_reset == e.clr, t, "mem_err_reset", mem_err_reset, e.clr);
            end
        end
    end

    initial begin
        for (int n = 0; n < WATCHDOG; n++) @(posedge clk);
        chk(1'b0, "WATCHDOG", "run timed out", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(ready == 1 && out_valid == 0 && halted == 0 && mem_err_reset == 0,
            "R12", "reset flags", {ready, out_valid, halted, mem_err_reset}, 4'b1000);
        chk(panel_code == 8'h00, "R12", "panel after reset", panel_code, 0);

        run_case(4'h0, 6'h3F, 16'h0000, "R3", 0, 0);          // breakpoint on zero status
        run_case(4'h1, 6'h20, 16'h0000, "R6", 0, 0);          // bus parity ignored
        run_case(4'h1, 6'h30, 16'h000C, "R6", 0, 0);          // bus parity + OOB, fatal, as break
        run_case(4'h1, 6'h10, 16'h8000, "R7", 0, 0);          // OOB notify
        run_case(4'h1, 6'h10, 16'h0008, "R7", 0, 0);          // OOB crash -> break (R10)
        run_case(4'h1, 6'h0D, 16'h8008, "R8", 0, 0);          // both MC2 beat MC1
        run_case(4'h1, 6'h08, 16'h0008, "R8", 0, 0);          // single MC2B
        run_case(4'h1, 6'h01, 16'h8000, "R9", 0, 0);          // MC1 notify
        run_case(4'h1, 6'h02, 16'h0008, "R9", 0, 0);          // MC1 crash -> break
        run_case(4'h1, 6'h00, 16'h8008, "R9", 0, 0);          // no flag
        run_case(4'h8, 6'h00, 16'h8000, "R5", 0, 0);          // stack notify
        run_case(4'h9, 6'h20, 16'h0008, "R5", 0, 0);          // stack + mem, crash -> break
        run_case(4'h4, 6'h00, 16'h8008, "R4", 0, 0);          // CS parity
        run_case(4'hF, 6'h00, 16'h0008, "R4", 0, 0);          // all bits
        run_case(4'h3, 6'h10, 16'h8008, "R2", 0, 0);          // no fast path with parity
        run_case(4'h1, 6'h04, 16'h0008, "R2", 1, 0);          // busy requests ignored (R1)

        // R11 fatal crash with halt
        run_case(4'hA, 6'h00, 16'h8000, "R11", 0, 1);
        chk(halted == 1'b1, "R11", "halted", halted, 1);
        chk(panel_code == 8'h2A, "R11", "panel_code", panel_code, 8'h2A);
        chk(ready == 1'b0, "R11", "ready stuck low", ready, 0);
        @(negedge clk);
        status = 4'h0; req_valid = 1'b1;
        repeat (4) @(negedge clk);
        req_valid = 1'b0;
        chk(halted == 1'b1 && out_valid == 1'b0, "R11", "request ignored while halted",
            {halted, out_valid}, 2'b10);
        chk(exp_q.size() == 0, "R11", "scoreboard drained", exp_q.size(), 0);

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ready == 1 && halted == 0 && panel_code == 0, "R12", "reset leaves halt",
            {ready, halted, panel_code}, 10'h200);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule